// File: doc/BRIEF.md
# Reduced Power Mode Controller

This block chooses the low-power state a small processor subsystem drops into when the core signals that it has executed a wait instruction, and it decides when the subsystem comes back. The choice depends on two things together: a two-bit mode code written by software and the core's deep-sleep flag. Each depth of sleep listens to its own set of wake sources. The deepest state can be left only by the real-time-clock alarm or by the external reset.

The interrupt request and enable lines arrive as parallel vectors. Their bit positions carry a fixed meaning:
- bit 0: non-maskable
- bits 1..4: external lines
- bit 5: GPIO
- bit 6: wake-on-LAN
- bit 7: brown-out
- bit 8: RTC alarm
- bit 9: CAN activity
- bit 10: USB activity
- bit 11: watchdog
- bits 12..15: ordinary peripheral interrupts

The controller drives a gate for the core clock and an enable for peripheral power. It also raises a one-cycle wake event on each return to Run, except a return from deep power-down. The mode register bus, the interrupt controller and the analog switches lie outside the block.

State codes on `cur_mode`:
- 0: Run
- 1: Sleep
- 2: Deep Sleep
- 3: Power-down
- 4: Deep Power-down

Top module: `reduced_power_ctrl`

## Requirements
- R1: In Run, a sleep request with deep flag 0 and mode code 00, 01 or 11 moves `cur_mode` to 1 (Sleep) one cycle after the request edge.
- R2: In Run, a sleep request with deep flag 1 moves `cur_mode` to 2 for code 00, to 3 for code 01, and to 4 for code 11.
- R3: Mode code 10 is reserved. A sleep request with that code leaves the controller in Run, whatever the deep flag.
- R4: In Sleep, any request line whose enable bit is set wakes the controller to Run.
- R5: In Deep Sleep and in Power-down, only enabled lines 0 to 10 wake the controller. Lines 12 to 15 and any disabled line have no effect.
- R6: Watchdog line 11, when enabled, wakes Deep Sleep only while `wdt_on_irc` is 1. It never wakes Power-down.
- R7: Deep Power-down is left only when line 8 is enabled and asserted, or when `rst_n` is low. Both exits land in Run without a wake event.
- R8: `core_clk_en` is 0 in every state other than Run. `periph_pwr_en` is 0 only in Deep Power-down.
- R9: A wake from Sleep, Deep Sleep or Power-down sets `cur_mode` to 0 and raises `wake_evt` for exactly one cycle, both one cycle after the edge where the wake source is seen.
- R10: If a wake source that qualifies for the target state is already active at the edge of a sleep request, the controller stays in Run and raises no wake event.
- R11: A sleep request received in any state other than Run is ignored.
- R12: After reset, `cur_mode` is 0, both enables are 1 and `wake_evt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| mode_code | input | 2 | Software low-power mode code |
| deep_flag | input | 1 | Deep-sleep flag from the core |
| sleep_req | input | 1 | One-cycle strobe on a wait instruction |
| irq_req | input | 16 | Interrupt request lines |
| irq_en | input | 16 | Enable bit per request line |
| wdt_on_irc | input | 1 | Watchdog clocked from the internal RC oscillator |
| cur_mode | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_pwr_en | output | 1 | Peripheral power enable |
| wake_evt | output | 1 | One-cycle wake event |

## Verification
A sleep request or a wake source takes effect at the next rising edge, and every result is due one cycle after that edge. The state appears on `cur_mode`, the enables follow from it, and `wake_evt` is registered at that same edge, so all of them change together. The bench drives inputs on falling edges. It checks each result at the falling edge that follows the acting rising edge, then checks once more a cycle later to confirm that the wake event has dropped. It sweeps every mode code, deep flag, request line, enable value and watchdog clock choice, and compares against a model written from the requirements.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_SLEEP  = 3'd1,
    PS_DSLEEP = 3'd2,
    PS_PDOWN  = 3'd3,
    PS_DPDOWN = 3'd4
  } pstate_t;

  localparam logic [1:0] MC_STD = 2'b00;
  localparam logic [1:0] MC_PD  = 2'b01;
  localparam logic [1:0] MC_RSV = 2'b10;
  localparam logic [1:0] MC_DPD = 2'b11;
endpackage

// File: rtl/rpm_target_decode.sv
module rpm_target_decode
  import rpm_pkg::*;
(
  input  logic [1:0] mode_code,
  input  logic       deep_flag,
  output pstate_t    target,
  output logic       target_valid
);
  always_comb begin
    target       = PS_RUN;
    target_valid = 1'b0;
    unique case (mode_code)
      MC_STD: begin
        target       = deep_flag ? PS_DSLEEP : PS_SLEEP;
        target_valid = 1'b1;
      end
      MC_PD: begin
        target       = deep_flag ? PS_PDOWN : PS_SLEEP;
        target_valid = 1'b1;
      end
      MC_DPD: begin
        target       = deep_flag ? PS_DPDOWN : PS_SLEEP;
        target_valid = 1'b1;
      end
      default: begin
        target       = PS_RUN;
        target_valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rpm_wake_qual.sv
module rpm_wake_qual #(
  parameter int                 NUM_IRQ   = 16,
  parameter logic [NUM_IRQ-1:0] DEEP_MASK = 16'h07FF,
  parameter int                 WDT_IDX   = 11,
  parameter int                 RTC_IDX   = 8
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               wdt_on_irc,
  output logic               wake_any,
  output logic               wake_pdown,
  output logic               wake_dsleep,
  output logic               wake_rtc
);
  logic [NUM_IRQ-1:0] live;
  logic [NUM_IRQ-1:0] deep_live;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign live[i] = irq_req[i] & irq_en[i];
    if (DEEP_MASK[i]) begin : g_deep
      assign deep_live[i] = live[i];
    end else begin : g_shallow
      assign deep_live[i] = 1'b0;
    end
  end

  assign wake_any    = |live;
  assign wake_pdown  = |deep_live;
  assign wake_dsleep = wake_pdown | (wdt_on_irc & live[WDT_IDX]);
  assign wake_rtc    = live[RTC_IDX];

  // Deep wake sources are a subset of all enabled sources (R5)
  assert_deep_subset_R5: assert final (!wake_pdown || wake_any);
endmodule

// File: rtl/rpm_state_ctrl.sv
module rpm_state_ctrl
  import rpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleep_req,
  input  pstate_t target,
  input  logic    target_valid,
  input  logic    wake_any,
  input  logic    wake_pdown,
  input  logic    wake_dsleep,
  input  logic    wake_rtc,
  output pstate_t state,
  output logic    wake_evt
);
  pstate_t state_q, state_nx;
  logic    pulse_q, pulse_nx;
  logic    state_upd;

  function automatic logic wake_for(pstate_t s, logic w_any, logic w_pd,
                                    logic w_ds, logic w_rtc);
    case (s)
      PS_SLEEP:  return w_any;
      PS_DSLEEP: return w_ds;
      PS_PDOWN:  return w_pd;
      PS_DPDOWN: return w_rtc;
      default:   return 1'b0;
    endcase
  endfunction

  always_comb begin
    state_nx = state_q;
    pulse_nx = 1'b0;
    case (state_q)
      PS_RUN: begin
        if (sleep_req && target_valid &&
            !wake_for(target, wake_any, wake_pdown, wake_dsleep, wake_rtc))
          state_nx = target;
      end
      PS_SLEEP, PS_DSLEEP, PS_PDOWN: begin
        if (wake_for(state_q, wake_any, wake_pdown, wake_dsleep, wake_rtc)) begin
          state_nx = PS_RUN;
          pulse_nx = 1'b1;
        end
      end
      PS_DPDOWN: begin
        if (wake_rtc) state_nx = PS_RUN;
      end
      default: state_nx = PS_RUN;
    endcase
  end

  assign state_upd = (state_nx != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      pulse_q <= 1'b0;
    end else begin
      if (state_upd) state_q <= state_nx;
      pulse_q <= pulse_nx;
    end
  end

  assign state    = state_q;
  assign wake_evt = pulse_q;

  // Low-power states are entered only from Run on a request (R11)
  assert_entry_from_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q) && state_q != PS_RUN)
      |-> ($past(state_q) == PS_RUN && $past(sleep_req)));

  // Wake event only on return from a shallow low-power state (R9)
  assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (state_q == PS_RUN && $past(state_q) != PS_RUN
                 && $past(state_q) != PS_DPDOWN));

  // Wake event lasts one cycle (R9)
  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // Deep power-down left only by the RTC line, silently (R7)
  assert_dpd_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_DPDOWN && state_q != PS_DPDOWN)
      |-> ($past(wake_rtc) && !pulse_q && state_q == PS_RUN));

  // Power-down ignores non-deep sources such as the watchdog (R6)
  assert_pdown_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_PDOWN && state_q == PS_RUN) |-> $past(wake_pdown));
endmodule

// File: rtl/reduced_power_ctrl.sv
module reduced_power_ctrl
  import rpm_pkg::*;
#(
  parameter int                 NUM_IRQ   = 16,
  parameter logic [NUM_IRQ-1:0] DEEP_MASK = 16'h07FF,
  parameter int                 WDT_IDX   = 11,
  parameter int                 RTC_IDX   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_code,
  input  logic               deep_flag,
  input  logic               sleep_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               wdt_on_irc,
  output logic [2:0]         cur_mode,
  output logic               core_clk_en,
  output logic               periph_pwr_en,
  output logic               wake_evt
);
  pstate_t target, state;
  logic    target_valid;
  logic    wake_any, wake_pdown, wake_dsleep, wake_rtc;

  rpm_target_decode u_decode (
    .mode_code    (mode_code),
    .deep_flag    (deep_flag),
    .target       (target),
    .target_valid (target_valid)
  );

  rpm_wake_qual #(
    .NUM_IRQ   (NUM_IRQ),
    .DEEP_MASK (DEEP_MASK),
    .WDT_IDX   (WDT_IDX),
    .RTC_IDX   (RTC_IDX)
  ) u_wake (
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .wdt_on_irc  (wdt_on_irc),
    .wake_any    (wake_any),
    .wake_pdown  (wake_pdown),
    .wake_dsleep (wake_dsleep),
    .wake_rtc    (wake_rtc)
  );

  rpm_state_ctrl u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .target       (target),
    .target_valid (target_valid),
    .wake_any     (wake_any),
    .wake_pdown   (wake_pdown),
    .wake_dsleep  (wake_dsleep),
    .wake_rtc     (wake_rtc),
    .state        (state),
    .wake_evt     (wake_evt)
  );

  assign cur_mode      = state;
  assign core_clk_en   = (state == PS_RUN);
  assign periph_pwr_en = (state != PS_DPDOWN);

  // Reserved code never leaves Run (R3)
  assert_reserved_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep_req) && $past(mode_code) == MC_RSV && $past(cur_mode) == 3'd0)
      |-> cur_mode == 3'd0);

  // Core clock gated whenever the peripherals are unpowered (R8)
  assert_gating_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_pwr_en |-> !core_clk_en);

  // Request with a qualifying wake already present stays in Run (R10)
  assert_no_bounce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_mode) == 3'd0 && $past(sleep_req) && $past(wake_any)
     && $past(!deep_flag)) |-> (cur_mode == 3'd0 && !wake_evt));
endmodule

// File: tb/reduced_power_ctrl_tb.sv
module reduced_power_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_code;
  logic        deep_flag;
  logic        sleep_req;
  logic [15:0] irq_req;
  logic [15:0] irq_en;
  logic        wdt_on_irc;
  logic [2:0]  cur_mode;
  logic        core_clk_en;
  logic        periph_pwr_en;
  logic        wake_evt;

  int vecs = 0;
  int fails = 0;

  always #10 clk = ~clk;

  reduced_power_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .deep_flag(deep_flag),
    .sleep_req(sleep_req), .irq_req(irq_req), .irq_en(irq_en),
    .wdt_on_irc(wdt_on_irc), .cur_mode(cur_mode), .core_clk_en(core_clk_en),
    .periph_pwr_en(periph_pwr_en), .wake_evt(wake_evt)
  );

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_target(int mc, int dp);
    if (mc == 2) return 0;
    if (dp == 0) return 1;
    if (mc == 0) return 2;
    if (mc == 1) return 3;
    return 4;
  endfunction

  function automatic int exp_wake(int st, int b, int en, int wdt);
    if (en == 0) return 0;
    case (st)
      1: return 1;
      2: return (b <= 10 || (b == 11 && wdt == 1)) ? 1 : 0;
      3: return (b <= 10) ? 1 : 0;
      4: return (b == 8) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sleep_req = 1'b0; irq_req = '0; irq_en = '0;
    mode_code = 2'b00; deep_flag = 1'b0; wdt_on_irc = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic request(int mc, int dp);
    mode_code = 2'(mc); deep_flag = dp[0]; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R12: actual 0 expected 1 (run completed)");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    int t, w;
    do_reset();
    chk("R12 mode", cur_mode, 0);
    chk("R12 clk_en", core_clk_en, 1);
    chk("R12 pwr_en", periph_pwr_en, 1);
    chk("R12 wake_evt", wake_evt, 0);

    for (int mc = 0; mc < 4; mc++)
      for (int dp = 0; dp < 2; dp++)
        for (int b = 0; b < 16; b++)
          for (int en = 0; en < 2; en++)
            for (int wdt = 0; wdt < 2; wdt++) begin
              do_reset();
              wdt_on_irc = wdt[0];
              request(mc, dp);
              t = exp_target(mc, dp);
              chk(t == 0 ? "R3 entry" : (dp == 0 ? "R1 entry" : "R2 entry"), cur_mode, t);
              chk("R8 clk_en", core_clk_en, t == 0 ? 1 : 0);
              chk("R8 pwr_en", periph_pwr_en, t == 4 ? 0 : 1);
              if (t != 0) begin
                irq_req = 16'(1 << b);
                irq_en  = en[0] ? 16'(1 << b) : 16'h0000;
                @(negedge clk);
                w = exp_wake(t, b, en, wdt);
                chk(t == 1 ? "R4 wake" : (t == 4 ? "R7 wake" :
                    (b == 11 ? "R6 wake" : "R5 wake")), cur_mode, w ? 0 : t);
                chk("R9 wake_evt", wake_evt, (w == 1 && t != 4) ? 1 : 0);
                irq_req = '0; irq_en = '0;
                @(negedge clk);
                chk("R9 pulse end", wake_evt, 0);
                if (t == 4 && w == 0) begin
                  do_reset();
                  chk("R7 reset exit", cur_mode, 0);
                end
              end
            end

    // R10: qualifying source present with the request
    do_reset();
    irq_req = 16'h0001; irq_en = 16'h0001;
    request(0, 1);
    chk("R10 stay run", cur_mode, 0);
    chk("R10 no pulse", wake_evt, 0);
    // R10: non-qualifying source present does not block entry
    do_reset();
    irq_req = 16'h2000; irq_en = 16'h2000;
    request(0, 1);
    chk("R10 enter anyway", cur_mode, 2);
    // R10: rtc active blocks deep power-down entry
    do_reset();
    irq_req = 16'h0100; irq_en = 16'h0100;
    request(3, 1);
    chk("R10 dpd blocked", cur_mode, 0);

    // R11: request while asleep ignored
    do_reset();
    request(0, 0);
    chk("R11 in sleep", cur_mode, 1);
    request(3, 1);
    chk("R11 ignored", cur_mode, 1);
    request(1, 1);
    chk("R11 ignored again", cur_mode, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule